// File: doc/BRIEF.md
# Serial NAND Programmed-I/O Shift Engine

This block sits between a word-wide register bus and a serial NAND flash device. Software moves every flash operation through it in short segments of one to four bytes. Each segment has its own byte count and lane width. To send a segment, software writes a write-command register that holds the byte count and the lane width, and then writes a 32-bit data word. The engine shifts that word out most-significant byte first over one, two or four data lanes. To receive, software writes a read-command register. The engine clocks in the programmed number of bytes and makes them available in a read-data register.

The chip-select lines come straight from a control register, so a select stays asserted across all segments of one flash operation. For example, an opcode segment can be followed by a quad-lane address segment and then by data segments, all under one select. The serial clock is a fixed half of the system clock and runs in mode 0. Software polls a busy flag in the status register before it touches the engine again. A write that arrives while the engine is busy is dropped.

Top module: `snand_pio_engine`

## Requirements
- R1: After reset, every chip-select output is high, the serial clock is low, no data lane is driven (io_oe = 0), and the status (0x40) and read-data (0x10) registers read as zero.
- R2: The chip-select register at 0x04 is active-low, and output cs_n[n] follows its bit 4*n. All 32 bits read back as written. Writing all ones releases every select.
- R3: The command registers at 0x08 (transmit) and 0x0C (receive) hold a count field in bits 1:0, equal to the byte count minus one, and a lane field in bits 29:28 (0 = one lane, 1 = two lanes, 2 or 3 = four lanes). Reading either register returns only these two fields, and all other bits read as zero.
- R4: When the engine is idle, a write to the data register at 0x14 sends the programmed number of bytes from that word. The first byte is bits 31:24, then the lower bytes in turn, each most-significant bit first. In one-lane mode the data leaves on lane 0.
- R5: In two-lane mode, each serial clock carries two bits, with the higher bit on lane 1 and the lower bit on lane 0. In four-lane mode, each clock carries a nibble on lanes 3..0. During a transmit, io_oe enables exactly the lanes in use.
- R6: When the engine is idle, a write to 0x0C receives the programmed number of bytes while no lane is driven. One-lane data is sampled on lane 1, two-lane data on lanes 1:0 (lane 1 higher), and four-lane data on lanes 3..0. Register 0x10 then holds the first byte in bits 31:24, with unused lower bytes zero. A transmit does not change register 0x10.
- R7: The serial clock idles low. Each serial clock period is two system clocks, high for one of them. A segment of N bytes on W lanes produces 8N/W clock pulses and keeps the engine busy for exactly 2*8N/W system clocks, counted from the starting write.
- R8: Status register 0x40 reads bit 3 = busy, bit 2 = receive in progress and bit 1 = transmit in progress. All other bits read as zero.
- R9: A write to 0x08, 0x0C or 0x14 while the engine is busy is ignored. It neither changes the stored fields nor starts or alters a segment.
- R10: Transfers never change the chip-select outputs. A select stays asserted across consecutive segments until the control register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Data lanes driven toward the flash |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Data lanes sampled from the flash |

## Verification
The bench builds the engine with its default parameters: an 8-bit register offset and two chip selects. These settings reach the status register at 0x40 and both select lines, including the one at bit 4. A vector table runs transmit and receive segments at every lane width and at byte counts of one to four. A behavioural flash model drives the lanes from the serial clock alone. Directed sequences cover the select register, command readback, and writes issued during a busy segment.

// File: rtl/snand_pkg.sv
package snand_pkg;

  localparam int unsigned WORD_W = 32;

  // Register byte offsets
  localparam logic [7:0] OFS_CS    = 8'h04;
  localparam logic [7:0] OFS_WCMD  = 8'h08;
  localparam logic [7:0] OFS_RCMD  = 8'h0C;
  localparam logic [7:0] OFS_RDATA = 8'h10;
  localparam logic [7:0] OFS_WDATA = 8'h14;
  localparam logic [7:0] OFS_STAT  = 8'h40;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_X4B = 2'd3
  } lane_e;

  typedef struct packed {
    lane_e      lane;
    logic [1:0] len;   // byte count minus one
  } seg_cfg_t;

  // log2 of the number of active lanes
  function automatic logic [1:0] lane_log2(input lane_e l);
    case (l)
      LANE_X1: return 2'd0;
      LANE_X2: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // serial clock pulses needed for one segment
  function automatic logic [5:0] beats_for(input seg_cfg_t c);
    logic [5:0] nbits;
    nbits = {({1'b0, c.len} + 3'd1), 3'b000};
    return nbits >> lane_log2(c.lane);
  endfunction

  function automatic logic [3:0] lane_oe(input lane_e l);
    case (l)
      LANE_X1: return 4'b0001;
      LANE_X2: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] pins_from(input logic [WORD_W-1:0] sr, input lane_e l);
    case (l)
      LANE_X1: return {3'b000, sr[WORD_W-1]};
      LANE_X2: return {2'b00, sr[WORD_W-1 -: 2]};
      default: return sr[WORD_W-1 -: 4];
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] shift_tx(input logic [WORD_W-1:0] sr, input lane_e l);
    case (l)
      LANE_X1: return {sr[WORD_W-2:0], 1'b0};
      LANE_X2: return {sr[WORD_W-3:0], 2'b00};
      default: return {sr[WORD_W-5:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] shift_rx(input logic [WORD_W-1:0] acc,
                                                 input logic [3:0] pins, input lane_e l);
    case (l)
      LANE_X1: return {acc[WORD_W-2:0], pins[1]};
      LANE_X2: return {acc[WORD_W-3:0], pins[1:0]};
      default: return {acc[WORD_W-5:0], pins};
    endcase
  endfunction

  // move a right-aligned capture of (len+1) bytes to the top of the word
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] acc,
                                                   input logic [1:0] len);
    logic [5:0] sh;
    sh = {1'b0, 2'd3 - len, 3'b000};
    return acc << sh;
  endfunction

  function automatic seg_cfg_t seg_decode(input logic [1:0] lane_bits, input logic [1:0] len_bits);
    seg_cfg_t c;
    c.lane = lane_e'(lane_bits);
    c.len  = len_bits;
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] seg_encode(input seg_cfg_t c);
    return {2'b00, c.lane, 26'd0, c.len};
  endfunction

endpackage

// File: rtl/snand_regfile.sv
module snand_regfile
  import snand_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              rx_act,
  input  logic              tx_act,
  input  logic              rx_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic [NUM_CS-1:0] cs_n,
  output logic              go,
  output logic              go_rx,
  output seg_cfg_t          go_cfg,
  output logic [WORD_W-1:0] go_word
);

  localparam logic [ADDR_W-1:0] A_CS    = ADDR_W'(OFS_CS);
  localparam logic [ADDR_W-1:0] A_WCMD  = ADDR_W'(OFS_WCMD);
  localparam logic [ADDR_W-1:0] A_RCMD  = ADDR_W'(OFS_RCMD);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFS_RDATA);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFS_WDATA);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam seg_cfg_t SEG_RST = '{lane: LANE_X1, len: 2'd0};

  logic [WORD_W-1:0] cs_q;
  logic [WORD_W-1:0] rdata_q;
  seg_cfg_t          wcmd_q;
  seg_cfg_t          rcmd_q;
  seg_cfg_t          wr_cfg;

  // named write events
  logic wr_cs, wr_wcmd, wr_rcmd, wr_wdata;
  assign wr_cs    = reg_we && (reg_addr == A_CS);
  assign wr_wcmd  = reg_we && (reg_addr == A_WCMD)  && !busy;
  assign wr_rcmd  = reg_we && (reg_addr == A_RCMD)  && !busy;
  assign wr_wdata = reg_we && (reg_addr == A_WDATA) && !busy;
  assign wr_cfg   = seg_decode(reg_wdata[29:28], reg_wdata[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '1;
      rdata_q <= '0;
      wcmd_q  <= SEG_RST;
      rcmd_q  <= SEG_RST;
    end else begin
      if (wr_cs)   cs_q    <= reg_wdata;
      if (wr_wcmd) wcmd_q  <= wr_cfg;
      if (wr_rcmd) rcmd_q  <= wr_cfg;
      if (rx_done) rdata_q <= rx_word;
    end
  end

  // segment launch toward the shifter
  assign go      = wr_wdata || wr_rcmd;
  assign go_rx   = wr_rcmd;
  assign go_cfg  = wr_rcmd ? wr_cfg : wcmd_q;
  assign go_word = reg_wdata;

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_n[g] = cs_q[4*g];
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CS:    reg_rdata = cs_q;
      A_WCMD:  reg_rdata = seg_encode(wcmd_q);
      A_RCMD:  reg_rdata = seg_encode(rcmd_q);
      A_RDATA: reg_rdata = rdata_q;
      A_STAT:  reg_rdata = {28'd0, busy, rx_act, tx_act, 1'b0};
      default: reg_rdata = '0;
    endcase
  end

  AST_WCMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && (reg_addr == A_WCMD) |=> wcmd_q == $past(wcmd_q)); // R9
  AST_RCMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && (reg_addr == A_RCMD) |=> rcmd_q == $past(rcmd_q)); // R9
  AST_CS_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == A_CS)) |=> $stable(cs_n)); // R10
  AST_RDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rdata_q)); // R6

endmodule

// File: rtl/snand_shifter.sv
module snand_shifter
  import snand_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rx,
  input  seg_cfg_t          go_cfg,
  input  logic [WORD_W-1:0] go_word,
  input  logic [3:0]        io_in,
  output logic              busy,
  output logic              rx_act,
  output logic              tx_act,
  output logic              sclk,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              rx_done,
  output logic [WORD_W-1:0] rx_word
);

  logic              active_q;
  logic              rx_q;
  logic              phase_q;   // 0: clock low half, 1: clock high half
  lane_e             lane_q;
  logic [1:0]        len_q;
  logic [5:0]        beats_q;   // pulses left, including the current one
  logic [WORD_W-1:0] tsr_q;
  logic [WORD_W-1:0] rsr_q;
  logic [WORD_W-1:0] rsr_nxt;

  // named internal events
  logic beat_end, last_beat;
  assign beat_end  = active_q && phase_q;
  assign last_beat = beat_end && (beats_q == 6'd1);
  assign rsr_nxt   = shift_rx(rsr_q, io_in, lane_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rx_q     <= 1'b0;
      phase_q  <= 1'b0;
      lane_q   <= LANE_X1;
      len_q    <= 2'd0;
      beats_q  <= 6'd0;
      tsr_q    <= '0;
      rsr_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      rx_q     <= go_rx;
      phase_q  <= 1'b0;
      lane_q   <= go_cfg.lane;
      len_q    <= go_cfg.len;
      beats_q  <= beats_for(go_cfg);
      tsr_q    <= go_word;
      rsr_q    <= '0;
    end else if (active_q) begin
      phase_q <= ~phase_q;
      if (beat_end) begin
        tsr_q   <= shift_tx(tsr_q, lane_q);
        rsr_q   <= rsr_nxt;
        beats_q <= beats_q - 6'd1;
        if (last_beat) active_q <= 1'b0;
      end
    end
  end

  assign busy    = active_q;
  assign rx_act  = active_q && rx_q;
  assign tx_act  = active_q && !rx_q;
  assign sclk    = phase_q;
  assign io_oe   = tx_act ? lane_oe(lane_q) : 4'b0000;
  assign io_out  = tx_act ? pins_from(tsr_q, lane_q) : 4'b0000;
  assign rx_done = last_beat && rx_q;
  assign rx_word = left_align(rsr_nxt, len_q);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R7
  AST_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> sclk != $past(sclk)); // R7
  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_act |-> io_oe == 4'b0000); // R6
  AST_TX_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_act |-> ($countones(io_oe) == 1 || $countones(io_oe) == 2 || $countones(io_oe) == 4)); // R5
  AST_BUSY_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go)); // R4
  AST_RX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !busy); // R6

endmodule

// File: rtl/snand_pio_engine.sv
module snand_pio_engine
  import snand_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  logic              busy, rx_act, tx_act, rx_done;
  logic              go, go_rx;
  seg_cfg_t          go_cfg;
  logic [WORD_W-1:0] go_word, rx_word;

  snand_regfile #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .rx_act    (rx_act),
    .tx_act    (tx_act),
    .rx_done   (rx_done),
    .rx_word   (rx_word),
    .cs_n      (cs_n),
    .go        (go),
    .go_rx     (go_rx),
    .go_cfg    (go_cfg),
    .go_word   (go_word)
  );

  snand_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .go_rx   (go_rx),
    .go_cfg  (go_cfg),
    .go_word (go_word),
    .io_in   (io_in),
    .busy    (busy),
    .rx_act  (rx_act),
    .tx_act  (tx_act),
    .sclk    (sclk),
    .io_out  (io_out),
    .io_oe   (io_oe),
    .rx_done (rx_done),
    .rx_word (rx_word)
  );

endmodule

// File: tb/tb_snand_pio_engine.sv
module tb_snand_pio_engine;

  localparam int ADDR_W = 8;
  localparam int NUM_CS = 2;
  localparam logic [7:0] A_CS = 8'h04, A_WCMD = 8'h08, A_RCMD = 8'h0C,
                         A_RDATA = 8'h10, A_WDATA = 8'h14, A_STAT = 8'h40;

  // {rx, lane[1:0], len[1:0], word}
  localparam logic [36:0] VEC [10] = '{
    {1'b0, 2'd0, 2'd0, 32'hA500_0000},
    {1'b0, 2'd0, 2'd3, 32'h9F12_3456},
    {1'b0, 2'd1, 2'd2, 32'h3C5A_F0AA},
    {1'b0, 2'd2, 2'd3, 32'hDEAD_BEEF},
    {1'b0, 2'd2, 2'd0, 32'h8155_5555},
    {1'b1, 2'd0, 2'd1, 32'hC3A5_7711},
    {1'b1, 2'd1, 2'd3, 32'h6B2D_9E47},
    {1'b1, 2'd2, 2'd2, 32'h1F2E_3D4C},
    {1'b1, 2'd0, 2'd3, 32'h8000_0001},
    {1'b0, 2'd1, 2'd1, 32'h0FF0_1234}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              sclk;
  logic [NUM_CS-1:0] cs_n;
  logic [3:0]        io_out, io_oe, io_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // flash model and monitor state
  logic [31:0] pat = '0;
  logic [31:0] cap = '0;
  logic [31:0] shp;
  logic [3:0]  exp_oe = 4'b0001;
  int          lw = 1;
  int          idx = 0;
  int          pulses = 0;
  int          oe_bad = 0;
  bit          mon_rx = 1'b0;
  logic        sclk_prev = 1'b0;

  always #4ns clk = ~clk;

  snand_pio_engine #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  assign shp   = pat << (idx * lw);
  assign io_in = (lw == 1) ? {2'b00, shp[31], 1'b0} :
                 (lw == 2) ? {2'b00, shp[31:30]} : shp[31:28];

  always @(negedge clk) begin
    if (sclk) begin
      pulses = pulses + 1;
      if (mon_rx) begin
        if (io_oe != 4'b0000) oe_bad = oe_bad + 1;
      end else begin
        if (io_oe != exp_oe) oe_bad = oe_bad + 1;
        cap = (cap << lw) | {28'd0, io_out & exp_oe};
      end
    end
    if (sclk_prev && !sclk) idx = idx + 1;
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1ns;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cnt);
    logic [31:0] s;
    cnt = 0;
    rd(A_STAT, s);
    while (s[3]) begin
      cnt++;
      @(negedge clk);
      rd(A_STAT, s);
    end
  endtask

  task automatic arm(input bit rx, input logic [1:0] lane, input logic [31:0] w);
    lw     = (lane == 2'd0) ? 1 : (lane == 2'd1) ? 2 : 4;
    exp_oe = (lane == 2'd0) ? 4'b0001 : (lane == 2'd1) ? 4'b0011 : 4'b1111;
    mon_rx = rx; pat = w; idx = 0; cap = '0; pulses = 0; oe_bad = 0;
  endtask

  initial begin
    logic [31:0] v, s, exp;
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 2'b11, "R1 cs_n after reset", 32'(cs_n), 32'h3);
    chk(sclk == 1'b0, "R1 sclk after reset", 32'(sclk), 32'h0);
    chk(io_oe == 4'b0000, "R1 io_oe after reset", 32'(io_oe), 32'h0);
    rd(A_STAT, v);  chk(v == 32'h0, "R1 status after reset", v, 32'h0);
    rd(A_RDATA, v); chk(v == 32'h0, "R1 rdata after reset", v, 32'h0);
    rst_n = 1'b1;

    // R2 select device 0
    wr(A_CS, 32'hFFFF_FFFE);
    chk(cs_n == 2'b10, "R2 select cs0", 32'(cs_n), 32'h2);

    for (int i = 0; i < 10; i++) begin
      logic        rx;
      logic [1:0]  lane, len;
      logic [31:0] w;
      int nb, beats;
      string tag;
      {rx, lane, len, w} = VEC[i];
      arm(rx, lane, w);
      nb    = int'(len) + 1;
      beats = nb * 8 / lw;
      if (rx) begin
        wr(A_RCMD, {2'b00, lane, 26'd0, len});
      end else begin
        wr(A_WCMD, {2'b00, lane, 26'd0, len});
        wr(A_WDATA, w);
      end
      rd(A_STAT, s);
      chk(s == (rx ? 32'hC : 32'hA), "R8 status during segment", s, rx ? 32'hC : 32'hA);
      wait_idle(cnt);
      chk(cnt == 2 * beats, "R7 busy cycles", 32'(cnt), 32'(2 * beats));
      chk(pulses == beats, "R7 sclk pulses", 32'(pulses), 32'(beats));
      chk(oe_bad == 0, rx ? "R6 lanes undriven on receive" : "R5 lane enables on transmit",
          32'(oe_bad), 32'h0);
      if (rx) begin
        exp = w & (32'hFFFF_FFFF << (32 - 8 * nb));
        rd(A_RDATA, v);
        chk(v == exp, "R6 received word", v, exp);
        rd(A_RCMD, v);
        chk(v == {2'b00, lane, 26'd0, len}, "R3 receive command readback", v, {2'b00, lane, 26'd0, len});
      end else begin
        exp = w >> (32 - 8 * nb);
        tag = (lw == 1) ? "R4 transmitted bytes" : "R5 transmitted bytes";
        chk(cap == exp, tag, cap, exp);
      end
      chk(cs_n == 2'b10, "R10 select held across segments", 32'(cs_n), 32'h2);
    end

    // R9 writes while busy are dropped
    arm(1'b0, 2'd0, 32'h0);
    wr(A_WCMD, 32'h0000_0000);
    wr(A_WDATA, 32'hF000_0000);
    wr(A_WDATA, 32'h0F00_0000);
    wr(A_WCMD, 32'h2000_0003);
    wr(A_RCMD, 32'h0000_0003);
    wait_idle(cnt);
    chk(cap == 32'hF0, "R9 busy data write ignored", cap, 32'hF0);
    chk(pulses == 8, "R9 busy command write ignored", 32'(pulses), 32'd8);
    rd(A_STAT, v);  chk(v == 32'h0, "R9 no receive started", v, 32'h0);
    rd(A_WCMD, v);  chk(v == 32'h0, "R9 transmit command unchanged", v, 32'h0);
    rd(A_RCMD, v);  chk(v == 32'h3, "R9 receive command unchanged", v, 32'h3);
    rd(A_RDATA, v); chk(v == 32'h8000_0001, "R6 rdata kept over transmit", v, 32'h8000_0001);

    // R3 readback keeps only the fields
    wr(A_WCMD, 32'hFFFF_FFFF);
    rd(A_WCMD, v); chk(v == 32'h3000_0003, "R3 command field readback", v, 32'h3000_0003);

    // R2 other select and release
    wr(A_CS, 32'hFFFF_FFEF);
    chk(cs_n == 2'b01, "R2 select cs1 via bit 4", 32'(cs_n), 32'h1);
    rd(A_CS, v); chk(v == 32'hFFFF_FFEF, "R2 select register readback", v, 32'hFFFF_FFEF);
    wr(A_CS, 32'hFFFF_FFFF);
    chk(cs_n == 2'b11, "R2 all ones releases", 32'(cs_n), 32'h3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule